// File: doc/BRIEF.md
# Thermal Alarm GPIO Event Detector

This block serves one general-purpose I/O pad. The pad can carry a thermal-alarm input that raises a power-management event. A direction control sets the pad's role. When the pad is an output, it carries a value from an output-data input. When the pad is an input, its level first passes through a multi-stage synchronizer into the bus clock domain. The synchronized level is then XORed with a polarity control. That adjusted level is captured only when a single-cycle 1 ms tick strobe arrives.

Trigger logic compares each new captured sample with the one before it. In edge mode, only a low-to-high move of the adjusted level counts. In toggle mode, any change of level counts. A trigger sets a sticky status flag. Software clears the flag with a write-one pulse. The event output is the status flag gated by an enable control.

The register decoding lives elsewhere. Every control arrives as a plain input port. The asynchronous active-low reset is released synchronously inside the block.

Top module: `gte_top`

## Requirements
- R1: After reset, with input mode selected, `sts` is 0, `evt` is 0 and `pin_level` is 0.
- R2: With `dir_in`=0, `pin_oe` is 1 and `pin_out` equals `out_data`. With `dir_in`=1, `pin_oe` is 0 and `pin_out` is 0.
- R3: In input mode, the pad level reaches the logic only through the synchronizer, and only on a cycle where `tick_1ms` is 1. `pin_level` shows the last captured adjusted level. In output mode, `pin_level` shows `out_data`.
- R4: The adjusted level equals `pin_in` XOR `pol_inv`.
- R5: With `trig_toggle`=0 (edge mode), `sts` is set only when the adjusted sample goes from 0 to 1 between two consecutive ticks. A move from 1 to 0 sets nothing.
- R6: With `trig_toggle`=1 (toggle mode), `sts` is set by any difference between two consecutive adjusted samples.
- R7: The first tick after reset, and the first tick after a return to input mode, only load the reference sample and never set `sts`.
- R8: Once set, `sts` stays 1 until a cycle with `sts_clr`=1 in input mode clears it.
- R9: When a trigger and `sts_clr` fall in the same cycle, `sts` ends at 1.
- R10: While `dir_in`=0, `sts` does not change. This holds for pad activity, ticks and `sts_clr` alike.
- R11: `evt` is 1 exactly when `sts` and `evt_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | Single-cycle sampling strobe, once per millisecond |
| pin_in | input | 1 | Level read from the pad |
| pin_out | output | 1 | Value driven to the pad |
| pin_oe | output | 1 | Pad output enable |
| dir_in | input | 1 | 1 = input mode, 0 = output mode |
| pol_inv | input | 1 | 1 = invert the pad level before triggering |
| trig_toggle | input | 1 | 0 = edge trigger, 1 = toggle trigger |
| out_data | input | 1 | Pad value in output mode |
| evt_en | input | 1 | Event output enable |
| sts_clr | input | 1 | Write-one clear pulse for the status flag |
| sts | output | 1 | Sticky trigger status |
| pin_level | output | 1 | Current captured level (input mode) or output data |
| evt | output | 1 | Power-management event |

## Verification
The bench builds the block with a three-stage pad synchronizer, one stage deeper than the default. This exercises the deeper branch of the generated chain. It also shows that the sampled result does not depend on chain depth, provided the pad is stable for a few cycles before each tick. The reset synchronizer keeps its default two stages, so the bench covers the synchronous release as it would ship. Random sequences of pad level, polarity, trigger mode and enable are mixed with direction flips and clear pulses. These reach priming after re-entry into input mode and a trigger colliding with a clear.

// File: rtl/gte_pkg.sv
package gte_pkg;
  typedef enum logic {
    TRIG_EDGE   = 1'b0,
    TRIG_TOGGLE = 1'b1
  } trig_mode_e;

  typedef struct packed {
    logic primed;
    logic prev;
    logic cur;
  } smp_state_t;
endpackage

// File: rtl/gte_sync.sv
module gte_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] q;
  logic [LAST:0] q_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb q_nxt = d;
    end else begin : g_chain
      always_comb q_nxt = {q[LAST-1:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign q_o = q[LAST];
endmodule

// File: rtl/gte_sample.sv
module gte_sample
  import gte_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic lvl,
  output logic cur,
  output logic prev,
  output logic vld
);
  smp_state_t st, st_nxt;
  logic       vld_q, vld_nxt;
  logic       st_ce;

  // Load enable: any tick in input mode, or the prime flag dropping in output mode.
  assign st_ce = tick | ~en;

  always_comb begin
    st_nxt  = st;
    vld_nxt = 1'b0;
    if (!en) begin
      st_nxt.primed = 1'b0;
    end else if (tick) begin
      if (!st.primed) begin
        st_nxt.primed = 1'b1;
        st_nxt.prev   = lvl;
        st_nxt.cur    = lvl;
      end else begin
        st_nxt.prev = st.cur;
        st_nxt.cur  = lvl;
        vld_nxt     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= '0;
      vld_q <= 1'b0;
    end else begin
      if (st_ce) st <= st_nxt;
      vld_q <= vld_nxt;
    end
  end

  assign cur  = st.cur;
  assign prev = st.prev;
  assign vld  = vld_q;

  p_capture_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(st.cur));
  p_vld_follows_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(tick));
  p_first_only_primes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !st.primed) |=> !vld_q);
endmodule

// File: rtl/gte_trig.sv
module gte_trig
  import gte_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  trig_mode_e mode,
  input  logic       vld,
  input  logic       cur,
  input  logic       prev,
  input  logic       clr,
  output logic       sts
);
  logic hit;
  logic sts_q, sts_nxt;

  always_comb begin
    hit = 1'b0;
    if (active && vld) begin
      unique case (mode)
        TRIG_EDGE:   hit = cur & ~prev;
        TRIG_TOGGLE: hit = cur ^ prev;
        default:     hit = 1'b0;
      endcase
    end
  end

  always_comb begin
    sts_nxt = sts_q;
    if (active) begin
      if (hit)      sts_nxt = 1'b1;
      else if (clr) sts_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= sts_nxt;
  end

  assign sts = sts_q;

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> sts_q);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && clr && !hit) |=> !sts_q);
  p_frozen_out_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(sts_q));
  p_rise_needs_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(vld));
endmodule

// File: rtl/gte_top.sv
module gte_top
  import gte_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1ms,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_oe,
  input  logic dir_in,
  input  logic pol_inv,
  input  logic trig_toggle,
  input  logic out_data,
  input  logic evt_en,
  input  logic sts_clr,
  output logic sts,
  output logic pin_level,
  output logic evt
);
  logic rst_n_s;
  logic pin_sync;
  logic lvl_adj;
  logic smp_cur, smp_prev, smp_vld;

  // Asynchronous assert, synchronous release.
  gte_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q_o  (rst_n_s)
  );

  gte_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .d    (pin_in),
    .q_o  (pin_sync)
  );

  assign lvl_adj = pin_sync ^ pol_inv;

  gte_sample u_sample (
    .clk  (clk),
    .rst_n(rst_n_s),
    .tick (tick_1ms),
    .en   (dir_in),
    .lvl  (lvl_adj),
    .cur  (smp_cur),
    .prev (smp_prev),
    .vld  (smp_vld)
  );

  gte_trig u_trig (
    .clk   (clk),
    .rst_n (rst_n_s),
    .active(dir_in),
    .mode  (trig_mode_e'(trig_toggle)),
    .vld   (smp_vld),
    .cur   (smp_cur),
    .prev  (smp_prev),
    .clr   (sts_clr),
    .sts   (sts)
  );

  assign pin_oe    = ~dir_in;
  assign pin_out   = dir_in ? 1'b0 : out_data;
  assign pin_level = dir_in ? smp_cur : out_data;
  assign evt       = sts & evt_en;

  p_evt_needs_sts_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(evt) |-> (evt_en && sts));
endmodule

// File: tb/sim_gte_top.sv
module sim_gte_top;
  localparam int CLK_P = 10;

  logic clk, rst_n, tick_1ms, pin_in, dir_in, pol_inv, trig_toggle;
  logic out_data, evt_en, sts_clr;
  logic pin_out, pin_oe, sts, pin_level, evt;

  int total, bad;
  bit done;
  // Reference model state.
  bit m_primed, m_prev, m_cur, m_sts, m_dir, m_out;

  gte_top #(.SYNC_STAGES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .dir_in(dir_in), .pol_inv(pol_inv),
    .trig_toggle(trig_toggle), .out_data(out_data), .evt_en(evt_en),
    .sts_clr(sts_clr), .sts(sts), .pin_level(pin_level), .evt(evt)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit trig_hit(bit mode, bit p, bit c);
    return mode ? (p ^ c) : (c & ~p);
  endfunction

  task automatic check_all();
    chk("R2 pin_oe", pin_oe, ~m_dir);
    chk("R2 pin_out", pin_out, m_dir ? 1'b0 : m_out);
    chk("R3 pin_level", pin_level, m_dir ? m_cur : m_out);
    chk("R5 R6 R7 R8 R9 R10 sts", sts, m_sts);
    chk("R11 evt", evt, m_sts & evt_en);
  endtask

  task automatic set_dir(input bit d, input bit od);
    @(negedge clk);
    dir_in = d; out_data = od;
    m_dir = d; m_out = od;
    if (!d) m_primed = 0;
    @(negedge clk);
    check_all();
  endtask

  // One tick with chosen pad level and controls; clr_hit pulses the clear
  // in the cycle where the trigger would land (R9).
  task automatic step(input bit pin, input bit pol, input bit mode,
                      input bit en, input bit clr_hit);
    bit lvl, hit;
    @(negedge clk);
    pin_in = pin; pol_inv = pol; trig_toggle = mode; evt_en = en;
    repeat (6) @(negedge clk);
    tick_1ms = 1'b1;
    @(negedge clk);
    tick_1ms = 1'b0; sts_clr = clr_hit;
    @(negedge clk);
    sts_clr = 1'b0;
    lvl = pin ^ pol;   // R4
    hit = 0;
    if (m_dir) begin
      if (!m_primed) begin
        m_primed = 1; m_prev = lvl; m_cur = lvl;
      end else begin
        m_prev = m_cur; m_cur = lvl;
        hit = trig_hit(mode, m_prev, m_cur);
      end
      if (hit) m_sts = 1;
      else if (clr_hit) m_sts = 0;
    end
    check_all();
  endtask

  task automatic clear();
    @(negedge clk);
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
    if (m_dir) m_sts = 0;
    check_all();
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0; tick_1ms = 0; pin_in = 0; dir_in = 1; pol_inv = 0;
    trig_toggle = 0; out_data = 0; evt_en = 1; sts_clr = 0;
    m_primed = 0; m_prev = 0; m_cur = 0; m_sts = 0; m_dir = 1; m_out = 0;
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sts", sts, 1'b0);
    chk("R1 evt", evt, 1'b0);
    chk("R1 pin_level", pin_level, 1'b0);

    // R7: the first tick primes even though the level is 1.
    step(1, 0, 0, 1, 0);
    chk("R7 no trigger on prime", sts, 1'b0);
    // R5: falling edge ignored, rising edge sets.
    step(0, 0, 0, 1, 0);
    chk("R5 fall ignored", sts, 1'b0);
    step(1, 0, 0, 1, 0);
    chk("R5 rise sets", sts, 1'b1);
    // R3: a pad pulse with no tick leaves the captured level alone.
    @(negedge clk); pin_in = 0; repeat (6) @(negedge clk);
    chk("R3 no tick no capture", pin_level, 1'b1);
    clear();
    chk("R8 cleared", sts, 1'b0);
    // R6: toggle mode catches a falling change.
    step(0, 0, 1, 1, 0);
    chk("R6 toggle fall sets", sts, 1'b1);
    // R11: enable low masks the event.
    step(0, 0, 1, 0, 0);
    chk("R11 masked", evt, 1'b0);
    clear();
    // R4: polarity makes a low pad read as 1, an edge-mode rise.
    step(0, 1, 0, 1, 0);
    chk("R4 inverted rise", sts, 1'b1);
    // R9: trigger and clear in one cycle.
    step(1, 1, 0, 1, 0);
    clear();
    step(0, 1, 0, 1, 1);
    chk("R9 set beats clear", sts, 1'b1);
    // R10: output mode freezes the status.
    set_dir(0, 1);
    step(1, 0, 1, 1, 0);
    clear();
    chk("R10 clear ignored", sts, 1'b1);
    set_dir(1, 0);
    clear();
    // R7: the first tick after returning only primes.
    step(1, 0, 1, 1, 0);
    chk("R7 re-entry primes", sts, 1'b0);

    for (int i = 0; i < 150; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0)      set_dir(~m_dir, 1'($urandom_range(0, 1)));
      else if (r == 1) clear();
      else step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                ($urandom_range(0, 4) == 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule